// File: doc/BRIEF.md
# GPIO Port with Interrupt Logic

A memory-mapped general purpose I/O port for up to 32 pins. Software reaches it through a simple word-addressed register bus: a single-cycle strobe with write flag, word address and write data, and a read data bus that presents the addressed register in the same cycle the strobe is held. The port drives the pad-side output value and an active-high output drive enable. It samples the pad inputs through a two-flop synchronizer, so every input-dependent result lags the pad by two clock edges.

The output word can be written whole, or changed bit by bit through a set alias and a clear alias. A write to either alias touches only the bits written as one. The direction register uses inverted sense: a one makes the pin an input and a zero makes it drive. Each pin can raise an interrupt on a level or on an edge, of either polarity. The polarity register can be rewritten at any time, so software can catch both edges by flipping a pin's polarity after each event. Pending conditions are gated by the enable and mask registers and merged into one interrupt line.

Register word offsets: 0 direction, 1 output, 2 set alias, 3 clear alias, 4 pin level, 5 interrupt enable, 6 interrupt type, 7 interrupt polarity, 8 interrupt mask, 9 interrupt pending.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register (offset 0) reads all ones, the output, enable, mask and pending registers read zero, `pad_oe` is all zero and `irq` is low.
- R2: A write to the set alias (offset 2) drives high every output bit written as one and leaves all other bits unchanged; the alias reads as zero.
- R3: A write to the clear alias (offset 3) drives low every output bit written as one and leaves all other bits unchanged; the alias reads as zero.
- R4: The output register (offset 1) can be written as a whole word, reads back what was written, and appears on `pad_out` after the write.
- R5: A direction bit of 1 makes the pin an input (`pad_oe` bit 0) and a 0 makes it drive (`pad_oe` bit 1); the direction register changes only when offset 0 is written.
- R6: The pin level register (offset 4) returns the synchronized pad input of every pin, whatever its direction; a pad change is visible in it after two rising clock edges, not after one.
- R7: With type bit 0 (edge mode), an enabled pin latches its pending bit (offset 9) on a rising edge when polarity is 1 and on a falling edge when polarity is 0; the bit stays set after the input returns, a write of 0 leaves it, and a write of 1 to it clears it.
- R8: With type bit 1 (level mode), an enabled pin's pending bit is 1 while the synchronized input equals its polarity bit and 0 otherwise; a write of 1 to that pending bit has no effect.
- R9: `irq` is high only when some pin has its pending, enable and mask bits all set; a pin with enable 0 captures no edge, and a pending pin with mask 0 does not raise `irq`.
- R10: A polarity bit rewritten while edge interrupts are active takes effect for the next edge: after flipping to 0 a falling edge is captured, and a rising edge no longer is.
- R11: Offsets 10 to 15 read as zero and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pad_in | input | 32 | Pad input levels |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad drive enable, 1 means drive |
| irq | output | 1 | Merged interrupt line |

## Verification
The detection logic is tried with rising and falling edges in edge mode, high and low levels in level mode, and a pin toggled in both directions while its polarity is flipped between events; this separates a design that latches edges from one that follows levels, and one that picks up polarity changes from one that ignores them. The enable and mask gates are exercised separately, so a swap of their roles shows up. Output patterns mix set, clear and whole-word writes with distinct bit groups, so a set or clear that disturbs zero bits is caught, and pad inputs are read back one and two edges after a change to pin down the synchronizer depth.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR   = 4'd0,
        REG_OUT   = 4'd1,
        REG_SET   = 4'd2,
        REG_CLR   = 4'd3,
        REG_PIN   = 4'd4,
        REG_IEN   = 4'd5,
        REG_ITYPE = 4'd6,
        REG_IPOL  = 4'd7,
        REG_IMASK = 4'd8,
        REG_IPEND = 4'd9
    } reg_addr_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] lvl,
    output logic [W-1:0] prev
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = pad_in;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign lvl  = pipe_q[STAGES-1];
    assign prev = pipe_q[STAGES];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_lvl,
    input  logic [W-1:0]      pend,
    output logic [W-1:0]      dir,
    output logic [W-1:0]      dout,
    output logic [W-1:0]      ien,
    output logic [W-1:0]      itype,
    output logic [W-1:0]      ipol,
    output logic [W-1:0]      imask,
    output logic [W-1:0]      pend_clr
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dout;
        logic [W-1:0] ien;
        logic [W-1:0] itype;
        logic [W-1:0] ipol;
        logic [W-1:0] imask;
    } regs_t;

    regs_t st_d, st_q;
    logic  wr_en;

    assign wr_en = bus_sel & bus_wr;

    always_comb begin
        st_d     = st_q;
        pend_clr = '0;
        if (wr_en) begin
            case (bus_addr)
                REG_DIR:   st_d.dir   = bus_wdata;
                REG_OUT:   st_d.dout  = bus_wdata;
                REG_SET:   st_d.dout  = st_q.dout | bus_wdata;
                REG_CLR:   st_d.dout  = st_q.dout & ~bus_wdata;
                REG_IEN:   st_d.ien   = bus_wdata;
                REG_ITYPE: st_d.itype = bus_wdata;
                REG_IPOL:  st_d.ipol  = bus_wdata;
                REG_IMASK: st_d.imask = bus_wdata;
                REG_IPEND: pend_clr   = bus_wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            REG_DIR:   bus_rdata = st_q.dir;
            REG_OUT:   bus_rdata = st_q.dout;
            REG_PIN:   bus_rdata = pin_lvl;
            REG_IEN:   bus_rdata = st_q.ien;
            REG_ITYPE: bus_rdata = st_q.itype;
            REG_IPOL:  bus_rdata = st_q.ipol;
            REG_IMASK: bus_rdata = st_q.imask;
            REG_IPEND: bus_rdata = pend;
            default:   bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.dir   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dir   = st_q.dir;
    assign dout  = st_q.dout;
    assign ien   = st_q.ien;
    assign itype = st_q.itype;
    assign ipol  = st_q.ipol;
    assign imask = st_q.imask;

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] ien,
    input  logic [W-1:0] itype,
    input  logic [W-1:0] ipol,
    input  logic [W-1:0] pend_clr,
    output logic [W-1:0] pend
);
    logic [W-1:0] pend_d, pend_q;
    logic [W-1:0] rise, fall, edge_hit, level_hit;

    always_comb begin
        rise      = lvl & ~prev;
        fall      = ~lvl & prev;
        edge_hit  = (rise & ipol) | (fall & ~ipol);
        level_hit = ~(lvl ^ ipol);
        for (int i = 0; i < W; i++) begin
            if (itype[i]) begin
                pend_d[i] = ien[i] & level_hit[i];
            end else begin
                // a fresh capture wins over a clear in the same cycle
                pend_d[i] = (pend_q[i] & ~pend_clr[i]) | (ien[i] & edge_hit[i]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    assign pend = pend_q;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int W           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe,
    output logic              irq
);
    logic [W-1:0] lvl_w, prev_w, pend_w, pend_clr_w;
    logic [W-1:0] dir_w, dout_w, ien_w, itype_w, ipol_w, imask_w;

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .lvl    (lvl_w),
        .prev   (prev_w)
    );

    gpio_regs #(.W(W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_lvl   (lvl_w),
        .pend      (pend_w),
        .dir       (dir_w),
        .dout      (dout_w),
        .ien       (ien_w),
        .itype     (itype_w),
        .ipol      (ipol_w),
        .imask     (imask_w),
        .pend_clr  (pend_clr_w)
    );

    gpio_irq #(.W(W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_w),
        .prev     (prev_w),
        .ien      (ien_w),
        .itype    (itype_w),
        .ipol     (ipol_w),
        .pend_clr (pend_clr_w),
        .pend     (pend_w)
    );

    assign pad_out = dout_w;
    assign pad_oe  = ~dir_w;
    assign irq     = |(pend_w & ien_w & imask_w);

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      pad_out,
    input logic              irq,
    input logic [W-1:0]      dir,
    input logic [W-1:0]      itype,
    input logic [W-1:0]      ien,
    input logic [W-1:0]      imask,
    input logic [W-1:0]      pend
);
    logic wr_en;
    assign wr_en = bus_sel & bus_wr;

    assert_set_drives_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == REG_SET) |=> ((pad_out & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clr_drives_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && bus_addr == REG_CLR) |=> ((pad_out & $past(bus_wdata)) == '0));

    assert_dir_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && bus_addr == REG_DIR) |=> $stable(dir));

    assert_edge_pend_latched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (bus_addr == REG_IPEND || bus_addr == REG_ITYPE))
        |=> ((($past(pend) & ~$past(itype)) & ~pend) == '0));

    assert_irq_needs_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((pend & ien) != '0));

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (imask == '0) |-> !irq);

endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .irq       (irq),
    .dir       (dir_w),
    .itype     (itype_w),
    .ien       (ien_w),
    .imask     (imask_w),
    .pend      (pend_w)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [3:0] A_DIR = 4'd0, A_OUT = 4'd1, A_SET = 4'd2, A_CLR = 4'd3,
                           A_PIN = 4'd4, A_IEN = 4'd5, A_TYP = 4'd6, A_POL = 4'd7,
                           A_MSK = 4'd8, A_PND = 4'd9;

    always #2 clk = ~clk;

    gpio_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_pad(input int bitn, input logic v);
        @(negedge clk);
        pad_in[bitn] = v;
        wait_cyc(5);
    endtask

    task automatic t_reset();
        logic [31:0] r;
        rd(A_DIR, r); chk("R1 dir", r, 32'hFFFF_FFFF);
        rd(A_OUT, r); chk("R1 out", r, 32'h0);
        rd(A_IEN, r); chk("R1 ien", r, 32'h0);
        rd(A_MSK, r); chk("R1 mask", r, 32'h0);
        rd(A_PND, r); chk("R1 pend", r, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_output();
        logic [31:0] r;
        wr(A_OUT, 32'h0000_00F0);
        wr(A_SET, 32'h0000_0003);
        chk("R2 set", pad_out, 32'h0000_00F3);
        rd(A_SET, r); chk("R2 alias reads 0", r, 32'h0);
        wr(A_CLR, 32'h0000_0030);
        chk("R3 clr", pad_out, 32'h0000_00C3);
        rd(A_CLR, r); chk("R3 alias reads 0", r, 32'h0);
        wr(A_OUT, 32'hA5A5_5A5A);
        rd(A_OUT, r); chk("R4 readback", r, 32'hA5A5_5A5A);
        chk("R4 pad_out", pad_out, 32'hA5A5_5A5A);
    endtask

    task automatic t_dir();
        logic [31:0] r;
        wr(A_DIR, 32'h0000_FFFF);
        chk("R5 pad_oe", pad_oe, 32'hFFFF_0000);
        wr(A_OUT, 32'h1234_0000);
        wr(A_SET, 32'h0000_0001);
        rd(A_DIR, r); chk("R5 dir untouched", r, 32'h0000_FFFF);
    endtask

    task automatic t_input();
        logic [31:0] r;
        @(negedge clk);
        pad_in = 32'h1234_0078;
        rd(A_PIN, r); chk("R6 one edge", r, 32'h0);
        rd(A_PIN, r); chk("R6 two edges", r, 32'h1234_0078);
        @(negedge clk);
        pad_in = 32'h0;
        wait_cyc(4);
        rd(A_PIN, r); chk("R6 back to 0", r, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd12, r); chk("R11 read 0", r, 32'h0);
        rd(A_OUT, r); chk("R11 out kept", r, 32'h1234_0001);
        rd(A_DIR, r); chk("R11 dir kept", r, 32'h0000_FFFF);
        rd(A_IEN, r); chk("R11 ien kept", r, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] r;
        wr(A_TYP, 32'h0);
        wr(A_POL, 32'h0000_0008);
        wr(A_MSK, 32'h0000_0018);
        wr(A_IEN, 32'h0000_0008);
        set_pad(3, 1'b1);
        rd(A_PND, r); chk("R7 rise pend", r, 32'h0000_0008);
        chk("R7 irq", {31'b0, irq}, 32'h1);
        set_pad(3, 1'b0);
        rd(A_PND, r); chk("R7 latched", r, 32'h0000_0008);
        wr(A_PND, 32'h0);
        rd(A_PND, r); chk("R7 w0 keeps", r, 32'h0000_0008);
        wr(A_PND, 32'h0000_0008);
        rd(A_PND, r); chk("R7 w1c", r, 32'h0);
        chk("R7 irq low", {31'b0, irq}, 32'h0);
        set_pad(4, 1'b1);
        wr(A_IEN, 32'h0000_0018);
        set_pad(4, 1'b0);
        rd(A_PND, r); chk("R7 fall pend", r, 32'h0000_0010);
        wr(A_PND, 32'h0000_0010);
        wr(A_IEN, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] r;
        wr(A_TYP, 32'h0000_0060);
        wr(A_POL, 32'h0000_0020);
        wr(A_MSK, 32'h0000_0060);
        wr(A_IEN, 32'h0000_0020);
        wait_cyc(3);
        rd(A_PND, r); chk("R8 idle", r, 32'h0);
        set_pad(5, 1'b1);
        rd(A_PND, r); chk("R8 high", r, 32'h0000_0020);
        chk("R8 irq", {31'b0, irq}, 32'h1);
        wr(A_PND, 32'h0000_0020);
        rd(A_PND, r); chk("R8 w1c no effect", r, 32'h0000_0020);
        set_pad(5, 1'b0);
        rd(A_PND, r); chk("R8 follows low", r, 32'h0);
        wr(A_IEN, 32'h0000_0040);
        wait_cyc(3);
        rd(A_PND, r); chk("R8 active low", r, 32'h0000_0040);
        set_pad(6, 1'b1);
        rd(A_PND, r); chk("R8 active low off", r, 32'h0);
        wr(A_IEN, 32'h0);
        wr(A_TYP, 32'h0);
    endtask

    task automatic t_gate();
        logic [31:0] r;
        wr(A_POL, 32'h0000_0080);
        wr(A_MSK, 32'h0000_0080);
        set_pad(7, 1'b1);
        rd(A_PND, r); chk("R9 no capture when disabled", r, 32'h0);
        chk("R9 irq off", {31'b0, irq}, 32'h0);
        set_pad(7, 1'b0);
        wr(A_MSK, 32'h0);
        wr(A_IEN, 32'h0000_0080);
        set_pad(7, 1'b1);
        rd(A_PND, r); chk("R9 captured", r, 32'h0000_0080);
        chk("R9 masked irq", {31'b0, irq}, 32'h0);
        wr(A_MSK, 32'h0000_0080);
        wait_cyc(1);
        chk("R9 unmasked irq", {31'b0, irq}, 32'h1);
        wr(A_PND, 32'h0000_0080);
        wr(A_IEN, 32'h0);
    endtask

    task automatic t_both();
        logic [31:0] r;
        wr(A_POL, 32'h0000_0100);
        wr(A_MSK, 32'h0000_0100);
        wr(A_IEN, 32'h0000_0100);
        set_pad(8, 1'b1);
        rd(A_PND, r); chk("R10 rise", r, 32'h0000_0100);
        wr(A_PND, 32'h0000_0100);
        wr(A_POL, 32'h0);
        set_pad(8, 1'b0);
        rd(A_PND, r); chk("R10 fall after flip", r, 32'h0000_0100);
        wr(A_PND, 32'h0000_0100);
        set_pad(8, 1'b1);
        rd(A_PND, r); chk("R10 rise ignored", r, 32'h0);
        chk("R10 irq low", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_output();
        t_dir();
        t_input();
        t_unmapped();
        t_edge();
        t_level();
        t_gate();
        t_both();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule